// File: doc/BRIEF.md
# Hint-Driven Fetch Throttle Controller

This block sits between the decode stage and the fetch stage of a wide superscalar front end. Every cycle it looks at a group of up to eight decoded instructions. A throttle request comes from one of two places. The first is a one-bit static hint attached to each instruction. The second is a dedicated marker instruction whose immediate carries an estimated IPC value; the marker requests a throttle when that value is at or below a programmable threshold. Throttle requests originate in compile-time analysis and not in runtime pipeline counters.

When a request is seen, the block halts new instruction fetch for a programmable number of cycles, normally one or two. It drives a fetch-stall flag and a fetch clock-enable qualifier. Both come straight from flip-flops, so the qualifier for the external clock gater changes only just after a rising clock edge. A pipeline flush cancels any pending stall. A global disable input keeps fetch running and ignores all requests.

Top module: `fetch_throttle_ctrl`

## Requirements
- R1: A lane whose decode-valid bit is 0 makes no request, whatever its hint bit or instruction word holds.
- R2: A valid lane with its hint bit set, in a group sampled at rising edge k, makes fetch_stall_o high and fetch_en_o low from edge k through edge k+dur_i-1. Both return to idle after edge k+dur_i.
- R3: Any number of requests in one group produce a single stall of dur_i cycles.
- R4: A request that arrives while a stall is active reloads the remaining stall to dur_i cycles. It does not add to the remaining count.
- R5: A valid lane is a marker when all of these hold: bits [31:26]=6'h11, bits [25:21]=31, bit 12=1, bits [11:5]=7'h40 and bits [4:0]=31. The IPC estimate is bits [20:13]. A marker requests a stall when that estimate is less than or equal to thresh_i, including at the limit 255/255. A word differing in any of these fields, such as destination register 30, is not a marker.
- R6: A flush_i sampled high ends any stall at the next edge and overrides a request in the same cycle.
- R7: While disable_i is high, fetch is enabled at the next edge, and hints and markers are ignored.
- R8: fetch_en_o is a register output and is always the inverse of fetch_stall_o. During reset and right after reset, fetch_en_o=1 and fetch_stall_o=0.
- R9: A dur_i of 0 turns requests into no stall at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 8 | Per-lane decode-valid bits |
| dec_hint_i | input | 8 | Per-lane static throttle hint bits |
| dec_instr_i | input | 256 | Instruction words; lane n is at bits [32n+31:32n] |
| thresh_i | input | 8 | IPC threshold for markers (typical value 2, or 3) |
| dur_i | input | 2 | Stall duration in cycles (typical value 1, or 2) |
| flush_i | input | 1 | Pipeline flush; clears any stall |
| disable_i | input | 1 | Global throttle disable |
| fetch_en_o | output | 1 | Registered clock-enable qualifier for the fetch stage |
| fetch_stall_o | output | 1 | Registered fetch-stall flag |

## Verification
The bench first targets the reload rule. A design that accumulates duration would keep the stall up for extra cycles after a second hint lands mid-stall. It then covers the marker threshold at equality, including 255 against 255, and a near-miss marker that writes register 30. An off-by-one comparison or a loose decode would throttle, or fail to throttle, in those cases. It also exercises hints on lanes with the valid bit clear, a flush or disable that arrives together with a hint, and a zero duration. A wrong priority in any of these would leave a stall showing where none belongs. Finally, reset is asserted in the middle of a stall, to catch a counter that is cleared only synchronously.

// File: rtl/fthr_pkg.sv
package fthr_pkg;
  localparam int unsigned LANES   = 8;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned IPC_W   = 8;
  localparam int unsigned DUR_W   = 2;

  // marker word: xor-immediate, zero register as source and destination
  localparam logic [5:0] MK_OPC  = 6'h11;
  localparam logic [6:0] MK_FUNC = 7'h40;
  localparam logic [4:0] ZERO_RG = 5'd31;
  localparam int unsigned IMM_LO = 13;

  function automatic logic is_marker(input logic [INSTR_W-1:0] w);
    return (w[31:26] == MK_OPC) && (w[25:21] == ZERO_RG) && w[12] &&
           (w[11:5] == MK_FUNC) && (w[4:0] == ZERO_RG);
  endfunction

  function automatic logic [IPC_W-1:0] marker_ipc(input logic [INSTR_W-1:0] w);
    return w[IMM_LO +: IPC_W];
  endfunction
endpackage

// File: rtl/fthr_lane_decode.sv
module fthr_lane_decode
  import fthr_pkg::*;
(
  input  logic               valid_i,
  input  logic               hint_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [IPC_W-1:0]   thresh_i,
  output logic               req_o
);
  logic mark_hit;

  always_comb begin
    mark_hit = is_marker(instr_i) && (marker_ipc(instr_i) <= thresh_i);
    req_o    = valid_i && (hint_i || mark_hit);
  end

  // R1: invalid lanes never request
  always_comb begin
    if (!valid_i) a_r1_invalid_quiet: assert (!req_o);
  end
endmodule

// File: rtl/fthr_stall_ctr.sv
module fthr_stall_ctr
  import fthr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             flush_i,
  input  logic             disable_i,
  output logic             fetch_en_o,
  output logic             fetch_stall_o
);
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             en_q, stall_q;

  always_comb begin
    if (flush_i || disable_i)  cnt_d = '0;
    else if (req_i)            cnt_d = dur_i;  // reload, never accumulate
    else if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
    else                       cnt_d = cnt_q;
  end

  // enable and stall are both flops so the gater qualifier only moves after the edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      en_q    <= 1'b1;
      stall_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      en_q    <= (cnt_d == '0);
      stall_q <= (cnt_d != '0);
    end
  end

  assign fetch_en_o    = en_q;
  assign fetch_stall_o = stall_q;

  a_r8_en_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o == !fetch_stall_o);
  a_r6_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !fetch_stall_o);
  a_r7_disable_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> fetch_en_o);
  a_r2_req_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !flush_i && !disable_i && dur_i != '0) |=> fetch_stall_o);
  a_r4_reload_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !flush_i && !disable_i) |=> cnt_q == $past(dur_i));
  a_r2_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_stall_o && !req_i && !flush_i && !disable_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r2_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_stall_o && !req_i) |=> !fetch_stall_o);
endmodule

// File: rtl/fetch_throttle_ctrl.sv
module fetch_throttle_ctrl
  import fthr_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LANES-1:0]         dec_valid_i,
  input  logic [LANES-1:0]         dec_hint_i,
  input  logic [LANES*INSTR_W-1:0] dec_instr_i,
  input  logic [IPC_W-1:0]         thresh_i,
  input  logic [DUR_W-1:0]         dur_i,
  input  logic                     flush_i,
  input  logic                     disable_i,
  output logic                     fetch_en_o,
  output logic                     fetch_stall_o
);
  logic [LANES-1:0] lane_req;
  logic             grp_req;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fthr_lane_decode u_dec (
      .valid_i  (dec_valid_i[g]),
      .hint_i   (dec_hint_i[g]),
      .instr_i  (dec_instr_i[g*INSTR_W +: INSTR_W]),
      .thresh_i (thresh_i),
      .req_o    (lane_req[g])
    );
  end

  // whole group collapses to one request
  assign grp_req = (|lane_req) && !disable_i;

  fthr_stall_ctr u_ctr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (grp_req),
    .dur_i         (dur_i),
    .flush_i       (flush_i),
    .disable_i     (disable_i),
    .fetch_en_o    (fetch_en_o),
    .fetch_stall_o (fetch_stall_o)
  );

  a_r1_no_valid_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i == '0 && !fetch_stall_o) |=> !fetch_stall_o);
  a_r7_disable_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |-> !grp_req);
endmodule

// File: tb/fetch_throttle_ctrl_bench.sv
module fetch_throttle_ctrl_bench;
  import fthr_pkg::*;

  logic                     clk_i = 1'b0;
  logic                     rst_ni = 1'b0;
  logic [LANES-1:0]         dec_valid_i = '0;
  logic [LANES-1:0]         dec_hint_i = '0;
  logic [LANES*INSTR_W-1:0] dec_instr_i = '0;
  logic [IPC_W-1:0]         thresh_i = 8'd2;
  logic [DUR_W-1:0]         dur_i = 2'd1;
  logic                     flush_i = 1'b0;
  logic                     disable_i = 1'b0;
  logic                     fetch_en_o, fetch_stall_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  fetch_throttle_ctrl u_fetch_throttle_ctrl (.*);

  // row: valid[41:34] hint[33:26] mlane[25:22](8=none) imm[21:14] th[13:6]
  //      dur[5:4] dis[3] flush[2] bad_dst[1] exp_stall[0]
  localparam int NROW = 24;
  localparam logic [41:0] TBL [NROW] = '{
    {8'h00,8'h00,4'd8,8'd0,  8'd2,  2'd1,1'b0,1'b0,1'b0,1'b0},
    {8'h01,8'h01,4'd8,8'd0,  8'd2,  2'd1,1'b0,1'b0,1'b0,1'b1},
    {8'h00,8'h00,4'd8,8'd0,  8'd2,  2'd1,1'b0,1'b0,1'b0,1'b0},
    {8'h00,8'hFF,4'd8,8'd0,  8'd2,  2'd1,1'b0,1'b0,1'b0,1'b0},
    {8'hFF,8'h81,4'd8,8'd0,  8'd2,  2'd2,1'b0,1'b0,1'b0,1'b1},
    {8'h00,8'h00,4'd8,8'd0,  8'd2,  2'd2,1'b0,1'b0,1'b0,1'b1},
    {8'h00,8'h00,4'd8,8'd0,  8'd2,  2'd2,1'b0,1'b0,1'b0,1'b0},
    {8'h08,8'h00,4'd3,8'd2,  8'd2,  2'd1,1'b0,1'b0,1'b0,1'b1},
    {8'h08,8'h00,4'd3,8'd3,  8'd2,  2'd1,1'b0,1'b0,1'b0,1'b0},
    {8'h08,8'h00,4'd3,8'd3,  8'd3,  2'd1,1'b0,1'b0,1'b0,1'b1},
    {8'h00,8'h00,4'd8,8'd0,  8'd2,  2'd1,1'b0,1'b0,1'b0,1'b0},
    {8'h01,8'h01,4'd8,8'd0,  8'd2,  2'd2,1'b0,1'b0,1'b0,1'b1},
    {8'h00,8'h00,4'd8,8'd0,  8'd2,  2'd2,1'b0,1'b0,1'b0,1'b1},
    {8'h01,8'h01,4'd8,8'd0,  8'd2,  2'd2,1'b0,1'b0,1'b0,1'b1},
    {8'h00,8'h00,4'd8,8'd0,  8'd2,  2'd2,1'b0,1'b0,1'b0,1'b1},
    {8'h01,8'h01,4'd8,8'd0,  8'd2,  2'd2,1'b0,1'b1,1'b0,1'b0},
    {8'h01,8'h01,4'd8,8'd0,  8'd2,  2'd2,1'b0,1'b0,1'b0,1'b1},
    {8'h01,8'h01,4'd8,8'd0,  8'd2,  2'd2,1'b1,1'b0,1'b0,1'b0},
    {8'h08,8'h00,4'd3,8'd0,  8'd2,  2'd1,1'b1,1'b0,1'b0,1'b0},
    {8'h00,8'h00,4'd8,8'd0,  8'd2,  2'd1,1'b0,1'b0,1'b0,1'b0},
    {8'h00,8'h00,4'd7,8'd0,  8'd2,  2'd1,1'b0,1'b0,1'b0,1'b0},
    {8'h20,8'h00,4'd5,8'd1,  8'd2,  2'd1,1'b0,1'b0,1'b1,1'b0},
    {8'h01,8'h01,4'd8,8'd0,  8'd2,  2'd0,1'b0,1'b0,1'b0,1'b0},
    {8'h80,8'h00,4'd7,8'd255,8'd255,2'd1,1'b0,1'b0,1'b0,1'b1}
  };

  function automatic string row_tag(input int i);
    case (i)
      0:                  return "R8";
      1, 2, 10, 16:       return "R2";
      3, 20:              return "R1";
      4, 5, 6:            return "R3";
      7, 8, 9, 21, 23:    return "R5";
      11, 12, 13, 14:     return "R4";
      15:                 return "R6";
      17, 18, 19:         return "R7";
      default:            return "R9";
    endcase
  endfunction

  function automatic logic [INSTR_W-1:0] mk_word(input logic [7:0] imm, input logic bad);
    return {6'h11, 5'd31, imm, 1'b1, 7'h40, (bad ? 5'd30 : 5'd31)};
  endfunction

  task automatic check(input string tag, input logic exp_stall);
    checks++;
    if (fetch_stall_o !== exp_stall || fetch_en_o !== !exp_stall) begin
      errors++;
      $display("FAIL %s: stall=%b en=%b expected stall=%b en=%b",
               tag, fetch_stall_o, fetch_en_o, exp_stall, !exp_stall);
    end
  endtask

  task automatic apply_row(input logic [41:0] r);
    logic [3:0] ml;
    dec_valid_i = r[41:34];
    dec_hint_i  = r[33:26];
    ml          = r[25:22];
    dec_instr_i = '0;
    if (ml < 4'd8) dec_instr_i[ml*INSTR_W +: INSTR_W] = mk_word(r[21:14], r[1]);
    thresh_i  = r[13:6];
    dur_i     = r[5:4];
    disable_i = r[3];
    flush_i   = r[2];
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    check("R8 reset", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 after reset", 1'b0);

    for (int i = 0; i < NROW; i++) begin
      apply_row(TBL[i]);
      @(negedge clk_i);
      check($sformatf("%s row %0d", row_tag(i), i), TBL[i][0]);
    end

    // R8: asynchronous reset in the middle of a stall
    apply_row({8'h01,8'h01,4'd8,8'd0,8'd2,2'd2,1'b0,1'b0,1'b0,1'b1});
    @(negedge clk_i);
    check("R2 pre-reset stall", 1'b1);
    apply_row('0);
    #1 rst_ni = 1'b0;
    #1 check("R8 async reset mid-stall", 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 idle after reset release", 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule